// File: doc/BRIEF.md
# Delayed-Branch Resolution Unit

This unit resolves control-transfer instructions for a 32-bit load/store pipeline that uses a branch delay slot. It takes one instruction word per cycle. With that word it takes the address of the word's delay slot and the two source operand values read from the register file. It reports four things: whether the word transfers control, whether the transfer is taken, the address that fetch should use next, and whether a return address must be written to a register, with its index and value.

The conditional branches, the absolute jumps and the register jumps are all resolved from the delay-slot address. The return address is the delay-slot address plus 4. For the "and-link" forms of the sign-test group, the return register is written whether or not the branch is taken. A register jump whose target is not word aligned is flagged as a fault. By default the unaligned address itself is placed on the next-address output so that exception logic can capture it. With `REPORT_MISALIGN` set to 0, the low two bits are dropped and no fault is raised.

All outputs are registered. A result appears one clock after the word is presented with `valid_in` high. Register-file access, fetch and the execution of ordinary instructions belong to other blocks.

Top module: `xfer_resolver`

## Requirements
- R1: Each output is registered with one cycle of latency. After reset, and in any cycle that follows a cycle with `valid_in` low, `valid_out`, `is_branch`, `taken`, `link_we` and `addr_err` are all 0.
- R2: Bits [31:26] of the word are the major opcode and bits [5:0] are the function field. A word is a control transfer only when its major opcode is 1 through 7, or when its major opcode is 0 and its function field is 8 or 9. For any other word, `is_branch`, `taken`, `link_we` and `addr_err` are 0 and `next_pc` equals the delay-slot address.
- R3: For opcodes 1 and 4–7, the taken target is the delay-slot address plus the sign-extended bits [15:0] shifted left by two.
- R4: Opcodes 2 and 3 always take the branch. Their target is bits [31:28] of the delay-slot address followed by bits [25:0] of the word and two zero bits.
- R5: Opcodes 4, 5, 6 and 7 take the branch when, respectively, rs equals rt, rs differs from rt, signed rs ≤ 0, and signed rs > 0.
- R6: For opcode 1, bit 16 of the word selects the test: 1 means take the branch when signed rs ≥ 0, and 0 means take it when rs < 0. No return address is written unless bits [20:17] are 1000.
- R7: For opcode 1 with bits [20:16] equal to 0x10 or 0x11, register 31 receives the delay-slot address plus 4 whether or not the branch is taken.
- R8: Opcode 3 writes register 31. Function 9 under opcode 0 writes the register named by bits [15:11], and writes nothing when that field is 0. Function 8 writes nothing. The written value is always the delay-slot address plus 4. When `link_we` is 0, `link_idx` and `link_val` are 0.
- R9: When a branch is not taken, `taken` is 0 and `next_pc` equals the delay-slot address.
- R10: A register jump (opcode 0, function 8 or 9) always takes the branch, and its target is rs. If rs[1:0] is nonzero, `addr_err` is 1 and `next_pc` carries rs unchanged (default `REPORT_MISALIGN`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | The input word and operands are valid |
| instr | input | 32 | Instruction word |
| ds_pc | input | 32 | Address of the word's delay slot |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| valid_out | output | 1 | The registered result is valid |
| is_branch | output | 1 | The word is a control transfer |
| taken | output | 1 | The transfer is taken |
| next_pc | output | 32 | Next fetch address |
| link_we | output | 1 | Write the return address |
| link_idx | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address value |
| addr_err | output | 1 | Unaligned register-jump target |

## Verification
The unit holds no state beyond its output register, so a wrong decode or wrong strobe shows up at the ports on the very next clock, in the result for the word that caused it. The directed vectors place the condition operands exactly on their sign and equality boundaries. Because of that placement, an inverted or off-by-one comparison flips `taken` and moves `next_pc` between the target and the delay-slot address. A link strobe tied to the taken decision rather than to the decode shows up as a missing `link_we` on a not-taken BLTZAL-style word.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int ADDR_W    = 32;
  localparam int IDX_W     = 5;
  localparam int IMM_W     = 16;
  localparam int JIDX_W    = 26;
  localparam int ALIGN_W   = 2;
  localparam int SEGBITS_W = ADDR_W - JIDX_W - ALIGN_W;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_SIGNTST = 6'd1;
  localparam logic [5:0] OP_JABS    = 6'd2;
  localparam logic [5:0] OP_JABSLNK = 6'd3;
  localparam logic [5:0] OP_CMPEQ   = 6'd4;
  localparam logic [5:0] OP_CMPNE   = 6'd5;
  localparam logic [5:0] OP_CMPLEZ  = 6'd6;
  localparam logic [5:0] OP_CMPGTZ  = 6'd7;

  localparam logic [4:0] FN_REGJUMP_HI = 5'b00100;
  localparam logic [3:0] RT_LINKGRP_HI = 4'b1000;

  typedef enum logic [2:0] {
    CND_ALWAYS,
    CND_EQ,
    CND_NE,
    CND_LEZ,
    CND_GTZ,
    CND_LTZ,
    CND_GEZ
  } cond_e;

  typedef enum logic [1:0] {
    TGT_REL,
    TGT_ABS,
    TGT_REG
  } tgt_e;

  typedef struct packed {
    logic  isXfer;
    logic  linkEn;
    logic  linkToRd;
    tgt_e  tgtSel;
    cond_e cond;
  } xferCtl_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic [5:0]       opField,
  input  logic [5:0]       fnField,
  input  logic [IDX_W-1:0] rtField,
  input  logic [IDX_W-1:0] rdField,
  output xferCtl_t         ctl
);

  logic isRegJump;
  logic rdNonZero;
  logic inLinkGrp;

  assign isRegJump = (fnField[5:1] == FN_REGJUMP_HI);
  assign rdNonZero = |rdField;
  assign inLinkGrp = (rtField[IDX_W-1:1] == RT_LINKGRP_HI);

  always_comb begin
    ctl.isXfer   = 1'b0;
    ctl.linkEn   = 1'b0;
    ctl.linkToRd = 1'b0;
    ctl.tgtSel   = TGT_REL;
    ctl.cond     = CND_ALWAYS;
    case (opField)
      OP_SPECIAL: begin
        if (isRegJump) begin
          ctl.isXfer   = 1'b1;
          ctl.tgtSel   = TGT_REG;
          ctl.linkToRd = 1'b1;
          ctl.linkEn   = fnField[0] && rdNonZero;
        end
      end
      OP_SIGNTST: begin
        ctl.isXfer = 1'b1;
        ctl.cond   = rtField[0] ? CND_GEZ : CND_LTZ;
        ctl.linkEn = inLinkGrp;
      end
      OP_JABS: begin
        ctl.isXfer = 1'b1;
        ctl.tgtSel = TGT_ABS;
      end
      OP_JABSLNK: begin
        ctl.isXfer = 1'b1;
        ctl.tgtSel = TGT_ABS;
        ctl.linkEn = 1'b1;
      end
      OP_CMPEQ: begin
        ctl.isXfer = 1'b1;
        ctl.cond   = CND_EQ;
      end
      OP_CMPNE: begin
        ctl.isXfer = 1'b1;
        ctl.cond   = CND_NE;
      end
      OP_CMPLEZ: begin
        ctl.isXfer = 1'b1;
        ctl.cond   = CND_LEZ;
      end
      OP_CMPGTZ: begin
        ctl.isXfer = 1'b1;
        ctl.cond   = CND_GTZ;
      end
      default: begin
        ctl.isXfer = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/xfer_dpath.sv
module xfer_dpath
  import xfer_pkg::*;
#(
  parameter bit               REPORT_MISALIGN = 1'b1,
  parameter logic [IDX_W-1:0] LINK_REG        = 5'd31
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  xferCtl_t          ctl,
  input  logic [ADDR_W-1:0] dsPc,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rtVal,
  input  logic [JIDX_W-1:0] jIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              validOut,
  output logic              isBranchOut,
  output logic              takenOut,
  output logic [ADDR_W-1:0] nextPcOut,
  output logic              linkWeOut,
  output logic [IDX_W-1:0]  linkIdxOut,
  output logic [ADDR_W-1:0] linkValOut,
  output logic              addrErrOut
);

  localparam int SEXT_W = ADDR_W - IMM_W - ALIGN_W;

  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] relTgt;
  logic [ADDR_W-1:0] absTgt;
  logic [ADDR_W-1:0] regTgt;
  logic [ADDR_W-1:0] selTgt;
  logic              misalign;
  logic              errFlag;
  logic              condMet;
  logic              takenNxt;
  logic [ADDR_W-1:0] nextPcNxt;
  logic              linkWeNxt;
  logic [IDX_W-1:0]  linkIdxNxt;
  logic [ADDR_W-1:0] linkValNxt;
  logic signed [ADDR_W-1:0] rsS;

  assign imm    = jIdx[IMM_W-1:0];
  assign rsS    = $signed(rsVal);
  assign relTgt = dsPc + {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
  assign absTgt = {dsPc[ADDR_W-1 -: SEGBITS_W], jIdx, {ALIGN_W{1'b0}}};
  assign misalign = (ctl.tgtSel == TGT_REG) && (|rsVal[ALIGN_W-1:0]);

  generate
    if (REPORT_MISALIGN) begin : g_report
      assign regTgt  = rsVal;
      assign errFlag = ctl.isXfer && misalign;
    end else begin : g_mask
      assign regTgt  = {rsVal[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      assign errFlag = 1'b0;
    end
  endgenerate

  always_comb begin
    case (ctl.tgtSel)
      TGT_ABS: selTgt = absTgt;
      TGT_REG: selTgt = regTgt;
      default: selTgt = relTgt;
    endcase
  end

  always_comb begin
    case (ctl.cond)
      CND_EQ:  condMet = (rsVal == rtVal);
      CND_NE:  condMet = (rsVal != rtVal);
      CND_LEZ: condMet = (rsS <= 0);
      CND_GTZ: condMet = (rsS > 0);
      CND_LTZ: condMet = rsS[ADDR_W-1];
      CND_GEZ: condMet = !rsS[ADDR_W-1];
      default: condMet = 1'b1;
    endcase
  end

  assign takenNxt   = ctl.isXfer && condMet;
  assign nextPcNxt  = takenNxt ? selTgt : dsPc;
  assign linkWeNxt  = ctl.isXfer && ctl.linkEn;
  assign linkIdxNxt = linkWeNxt ? (ctl.linkToRd ? rdIdx : LINK_REG) : '0;
  assign linkValNxt = linkWeNxt ? (dsPc + ADDR_W'(4)) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut    <= 1'b0;
      isBranchOut <= 1'b0;
      takenOut    <= 1'b0;
      nextPcOut   <= '0;
      linkWeOut   <= 1'b0;
      linkIdxOut  <= '0;
      linkValOut  <= '0;
      addrErrOut  <= 1'b0;
    end else if (validIn) begin
      validOut    <= 1'b1;
      isBranchOut <= ctl.isXfer;
      takenOut    <= takenNxt;
      nextPcOut   <= nextPcNxt;
      linkWeOut   <= linkWeNxt;
      linkIdxOut  <= linkIdxNxt;
      linkValOut  <= linkValNxt;
      addrErrOut  <= errFlag;
    end else begin
      validOut    <= 1'b0;
      isBranchOut <= 1'b0;
      takenOut    <= 1'b0;
      nextPcOut   <= '0;
      linkWeOut   <= 1'b0;
      linkIdxOut  <= '0;
      linkValOut  <= '0;
      addrErrOut  <= 1'b0;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> !(isBranchOut || takenOut || linkWeOut || addrErrOut)); // R1
  AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !isBranchOut) |-> !(takenOut || linkWeOut || addrErrOut)); // R2
  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !takenOut) |-> (nextPcOut == $past(dsPc))); // R9
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    linkWeOut |-> ((linkValOut == $past(dsPc) + ADDR_W'(4)) && (linkIdxOut != '0))); // R8
  AST_FAULT_ON_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    addrErrOut |-> (takenOut && isBranchOut && (|nextPcOut[ALIGN_W-1:0]))); // R10

endmodule

// File: rtl/xfer_resolver.sv
module xfer_resolver
  import xfer_pkg::*;
#(
  parameter bit               REPORT_MISALIGN = 1'b1,
  parameter logic [IDX_W-1:0] LINK_REG        = 5'd31
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] ds_pc,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic [ADDR_W-1:0] rt_val,
  output logic              valid_out,
  output logic              is_branch,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              link_we,
  output logic [IDX_W-1:0]  link_idx,
  output logic [ADDR_W-1:0] link_val,
  output logic              addr_err
);

  xferCtl_t ctlStrobes;

  xfer_ctrl u_ctrl (
    .opField (instr[31:26]),
    .fnField (instr[5:0]),
    .rtField (instr[20:16]),
    .rdField (instr[15:11]),
    .ctl     (ctlStrobes)
  );

  xfer_dpath #(
    .REPORT_MISALIGN (REPORT_MISALIGN),
    .LINK_REG        (LINK_REG)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rst_n),
    .validIn     (valid_in),
    .ctl         (ctlStrobes),
    .dsPc        (ds_pc),
    .rsVal       (rs_val),
    .rtVal       (rt_val),
    .jIdx        (instr[25:0]),
    .rdIdx       (instr[15:11]),
    .validOut    (valid_out),
    .isBranchOut (is_branch),
    .takenOut    (taken),
    .nextPcOut   (next_pc),
    .linkWeOut   (link_we),
    .linkIdxOut  (link_idx),
    .linkValOut  (link_val),
    .addrErrOut  (addr_err)
  );

endmodule

// File: tb/xfer_resolver_tb.sv
`timescale 1ns/1ps
module xfer_resolver_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] dsPc = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic        validOut, isBranch, taken, linkWe, addrErr;
  logic [31:0] nextPc, linkVal;
  logic [4:0]  linkIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xfer_resolver u_dut (
    .clk(clk), .rst_n(rstN), .valid_in(validIn), .instr(instr),
    .ds_pc(dsPc), .rs_val(rsVal), .rt_val(rtVal),
    .valid_out(validOut), .is_branch(isBranch), .taken(taken),
    .next_pc(nextPc), .link_we(linkWe), .link_idx(linkIdx),
    .link_val(linkVal), .addr_err(addrErr)
  );

  function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] jw(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  function automatic logic [31:0] rw(input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, 5'd3, 5'd0, rd, 5'd0, fn};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [31:0] ds,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    validIn = 1'b1; instr = w; dsPc = ds; rsVal = a; rtVal = b;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic eBr, input logic eTk,
                            input logic [31:0] ePc, input logic eWe,
                            input logic [4:0] eIdx, input logic [31:0] eVal,
                            input logic eErr);
    nChecks++;
    if ({validOut, isBranch, taken, nextPc, linkWe, linkIdx, linkVal, addrErr} !==
        {1'b1, eBr, eTk, ePc, eWe, eIdx, eVal, eErr}) begin
      nFails++;
      $display("FAIL %s: got v=%0b br=%0b tk=%0b pc=%h we=%0b idx=%0d lv=%h err=%0b exp v=1 br=%0b tk=%0b pc=%h we=%0b idx=%0d lv=%h err=%0b",
               tag, validOut, isBranch, taken, nextPc, linkWe, linkIdx, linkVal, addrErr,
               eBr, eTk, ePc, eWe, eIdx, eVal, eErr);
    end
  endtask

  task automatic expect_idle(input string tag);
    nChecks++;
    if ({validOut, isBranch, taken, linkWe, addrErr} !== 5'b0) begin
      nFails++;
      $display("FAIL %s: got v=%0b br=%0b tk=%0b we=%0b err=%0b exp all 0",
               tag, validOut, isBranch, taken, linkWe, addrErr);
    end
  endtask

  task automatic t_reset_idle();
    expect_idle("R1 reset");
    apply(iw(6'd4, 5'd1, 5'd2, 16'h0001), 32'h100, 32'd0, 32'd0);
    expect_out("R1 latency", 1, 1, 32'h104, 0, 0, 0, 0);
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    expect_idle("R1 idle after valid low");
  endtask

  task automatic t_nonbranch();
    apply(rw(5'd7, 6'h0A), 32'h500, 32'h4, 32'h0);
    expect_out("R2 fn 0x0A", 0, 0, 32'h500, 0, 0, 0, 0);
    apply(rw(5'd7, 6'h20), 32'h504, 32'h4, 32'h0);
    expect_out("R2 fn 0x20", 0, 0, 32'h504, 0, 0, 0, 0);
    apply(iw(6'd8, 5'd1, 5'd2, 16'h0010), 32'h508, 32'h0, 32'h0);
    expect_out("R2 opcode 8", 0, 0, 32'h508, 0, 0, 0, 0);
    apply(iw(6'h23, 5'd1, 5'd2, 16'h0010), 32'h50C, 32'h0, 32'h0);
    expect_out("R2 opcode 0x23", 0, 0, 32'h50C, 0, 0, 0, 0);
  endtask

  task automatic t_compare();
    apply(iw(6'd4, 5'd1, 5'd2, 16'h0010), 32'h1000, 32'd5, 32'd5);
    expect_out("R5 R3 eq taken", 1, 1, 32'h1040, 0, 0, 0, 0);
    apply(iw(6'd5, 5'd1, 5'd2, 16'h0010), 32'h1000, 32'd5, 32'd5);
    expect_out("R5 R9 ne not taken", 1, 0, 32'h1000, 0, 0, 0, 0);
    apply(iw(6'd4, 5'd1, 5'd2, 16'hFFFC), 32'h2000, 32'd1, 32'd2);
    expect_out("R5 R9 eq not taken", 1, 0, 32'h2000, 0, 0, 0, 0);
    apply(iw(6'd5, 5'd1, 5'd2, 16'hFFFC), 32'h2000, 32'd1, 32'd2);
    expect_out("R3 ne negative offset", 1, 1, 32'h1FF0, 0, 0, 0, 0);
    apply(iw(6'd6, 5'd1, 5'd0, 16'h0002), 32'h3000, 32'd0, 32'd0);
    expect_out("R5 lez zero", 1, 1, 32'h3008, 0, 0, 0, 0);
    apply(iw(6'd6, 5'd1, 5'd0, 16'h0002), 32'h3000, 32'h80000000, 32'd0);
    expect_out("R5 lez most negative", 1, 1, 32'h3008, 0, 0, 0, 0);
    apply(iw(6'd6, 5'd1, 5'd0, 16'h0002), 32'h3000, 32'd1, 32'd0);
    expect_out("R5 lez one", 1, 0, 32'h3000, 0, 0, 0, 0);
    apply(iw(6'd7, 5'd1, 5'd0, 16'h0002), 32'h3000, 32'd1, 32'd0);
    expect_out("R5 gtz one", 1, 1, 32'h3008, 0, 0, 0, 0);
    apply(iw(6'd7, 5'd1, 5'd0, 16'h0002), 32'h3000, 32'hFFFFFFFF, 32'd0);
    expect_out("R5 gtz minus one", 1, 0, 32'h3000, 0, 0, 0, 0);
    apply(iw(6'd7, 5'd1, 5'd0, 16'h0002), 32'h3000, 32'd0, 32'd0);
    expect_out("R5 gtz zero", 1, 0, 32'h3000, 0, 0, 0, 0);
  endtask

  task automatic t_signtest();
    apply(iw(6'd1, 5'd1, 5'd0, 16'h0004), 32'h4000, 32'hFFFFFFFF, 32'd0);
    expect_out("R6 ltz taken", 1, 1, 32'h4010, 0, 0, 0, 0);
    apply(iw(6'd1, 5'd1, 5'd0, 16'h0004), 32'h4000, 32'd0, 32'd0);
    expect_out("R6 ltz zero not taken", 1, 0, 32'h4000, 0, 0, 0, 0);
    apply(iw(6'd1, 5'd1, 5'd1, 16'h0004), 32'h4000, 32'd0, 32'd0);
    expect_out("R6 gez zero taken", 1, 1, 32'h4010, 0, 0, 0, 0);
    apply(iw(6'd1, 5'd1, 5'd3, 16'h0004), 32'h4000, 32'hFFFFFFFB, 32'd0);
    expect_out("R6 rt 3 gez not taken", 1, 0, 32'h4000, 0, 0, 0, 0);
    apply(iw(6'd1, 5'd1, 5'd2, 16'h0004), 32'h4000, 32'hFFFFFFFB, 32'd0);
    expect_out("R6 rt 2 ltz taken", 1, 1, 32'h4010, 0, 0, 0, 0);
    apply(iw(6'd1, 5'd1, 5'h18, 16'h0004), 32'h4000, 32'hFFFFFFFB, 32'd0);
    expect_out("R6 rt 0x18 no link", 1, 1, 32'h4010, 0, 0, 0, 0);
    apply(iw(6'd1, 5'd1, 5'h10, 16'h0004), 32'h4000, 32'd5, 32'd0);
    expect_out("R7 ltz-link not taken", 1, 0, 32'h4000, 1, 5'd31, 32'h4004, 0);
    apply(iw(6'd1, 5'd1, 5'h11, 16'h0004), 32'h4000, 32'd5, 32'd0);
    expect_out("R7 gez-link taken", 1, 1, 32'h4010, 1, 5'd31, 32'h4004, 0);
    apply(iw(6'd1, 5'd1, 5'h11, 16'h0004), 32'h4000, 32'hFFFFFFFF, 32'd0);
    expect_out("R7 gez-link not taken", 1, 0, 32'h4000, 1, 5'd31, 32'h4004, 0);
  endtask

  task automatic t_absjump();
    apply(jw(6'd2, 26'h0123456), 32'hA0000010, 32'd0, 32'd0);
    expect_out("R4 jump", 1, 1, 32'hA048D158, 0, 0, 0, 0);
    apply(jw(6'd3, 26'h0123456), 32'hA0000010, 32'd0, 32'd0);
    expect_out("R4 R8 jump-link", 1, 1, 32'hA048D158, 1, 5'd31, 32'hA0000014, 0);
  endtask

  task automatic t_regjump();
    apply(rw(5'd0, 6'h08), 32'h6000, 32'h80001230, 32'd0);
    expect_out("R10 R8 reg jump no link", 1, 1, 32'h80001230, 0, 0, 0, 0);
    apply(rw(5'd7, 6'h09), 32'h6000, 32'h00000400, 32'd0);
    expect_out("R8 reg jump link rd", 1, 1, 32'h00000400, 1, 5'd7, 32'h6004, 0);
    apply(rw(5'd0, 6'h09), 32'h6000, 32'h00000400, 32'd0);
    expect_out("R8 reg jump link rd zero", 1, 1, 32'h00000400, 0, 0, 0, 0);
    apply(rw(5'd0, 6'h08), 32'h6000, 32'h00001002, 32'd0);
    expect_out("R10 misaligned", 1, 1, 32'h00001002, 0, 0, 0, 1);
    apply(rw(5'd9, 6'h09), 32'h6000, 32'h00001001, 32'd0);
    expect_out("R10 misaligned with link", 1, 1, 32'h00001001, 1, 5'd9, 32'h6004, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_nonbranch();
    t_compare();
    t_signtest();
    t_absjump();
    t_regjump();
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    expect_idle("R1 final idle");
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule